// File: doc/BRIEF.md
# Multi-Channel Transmit Descriptor Engine

This block runs the transmit side of a packet DMA for up to four channels. Every channel owns a descriptor table of up to 64 slots, each slot 16 bytes, placed on a 1024-byte boundary. Every channel also has a transmit-enable flag, which a one-cycle strobe sets. While at least one flag is set, the engine picks a channel in round-robin order and reads the four words of that channel's current descriptor through a word-read port. It then streams the header buffer and the data buffer as bytes into a transmitter FIFO and closes the packet with an end-of-packet marker. After that it rewrites the control word with the enable bit cleared, advances the channel's slot pointer and arbitrates again.

The header and the data part each have their own pointer and length. A part of length zero is skipped, and if both parts are zero no packet is sent. Per-part flags ask a downstream checksum unit to insert a CRC. The engine signals this with a strobe that marks the last byte of that part. When the engine reaches a slot whose enable bit is clear, it drops the channel's transmit-enable flag and serves no more packets on that channel until software sets the flag again.

Top module: `spw_txdesc_engine`

## Requirements
- R1: Descriptor slot i of a channel lies at byte address table_base + 16*i. Word 0 holds the header length in bits 7:0, enable in bit 12, wrap in bit 13, interrupt request in bit 14, header-CRC in bit 16 and data-CRC in bit 17. Word 1 (offset 4) is the header byte address. Word 2 (offset 8) holds the data length in bits 23:0. Word 3 (offset 12) is the data byte address.
- R2: A packet is the header bytes in address order, then the data bytes in address order, then one marker entry with fifo_data[8]=1 and fifo_data[7:0]=0. Byte entries have fifo_data[8]=0. Memory is big-endian: the byte at address a is bits 31-8*(a mod 4) down to 24-8*(a mod 4) of the word at a with its low two bits cleared. Any byte alignment is allowed.
- R3: A header length of zero skips the header part, and a data length of zero skips the data part.
- R4: A descriptor whose two lengths are both zero pushes nothing, not even the marker, but it is still written back and retired.
- R5: fifo_push is never high while fifo_full is high.
- R6: crc_hdr_ins is high exactly with the push of the last header byte when the header-CRC bit is set. crc_dat_ins is high exactly with the push of the last data byte when the data-CRC bit is set. Neither strobe appears at any other time.
- R7: After the marker (or at once for an empty descriptor), word 0 is written back to the same slot address with bit 12 cleared and all other bits unchanged.
- R8: tx_irq[c] pulses for one cycle, in the cycle the write-back of channel c is acknowledged, if the interrupt-request bit of that descriptor is set. At most one bit of tx_irq is high at a time.
- R9: After a retired descriptor, the slot pointer returns to 0 if the wrap bit was set or the slot was 63, and otherwise it increments. A strobe on tbl_base_we[c] loads the table base and resets the pointer of channel c to slot 0.
- R10: When the enable bit of the current slot is clear, the channel's tx_en flag falls, and nothing is pushed or written for that slot.
- R11: Among channels whose tx_en is set, the next one served is the first found after the channel most recently granted, in ascending channel order with wrap-around. After reset, channel 0 has the highest priority. A channel holds the engine for one whole packet.
- R12: A strobe on tx_en_set[c] sets tx_en[c], and a set wins over a clear in the same cycle. With no tx_en bit set, the engine issues no memory access.
- R13: A memory read holds mem_rd_req and mem_rd_addr stable until mem_rd_ack. Read data is taken in the acknowledge cycle, and a read and a write are never requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base_we | input | NCH | Per-channel strobe: load table base, reset slot pointer |
| tbl_base | input | AW-10 | Table base address bits AW-1 down to 10 |
| tx_en_set | input | NCH | Per-channel strobe setting the transmit-enable flag |
| tx_en | output | NCH | Transmit-enable flags |
| mem_rd_req | output | 1 | Word read request |
| mem_rd_addr | output | AW | Byte address of the word read (word aligned) |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Descriptor write-back request |
| mem_wr_addr | output | AW | Write-back byte address |
| mem_wr_data | output | 32 | Write-back data |
| mem_wr_ack | input | 1 | Write acknowledge |
| fifo_full | input | 1 | Transmitter FIFO cannot accept an entry |
| fifo_push | output | 1 | FIFO push |
| fifo_data | output | 9 | Bit 8 end-of-packet marker, bits 7:0 byte |
| crc_hdr_ins | output | 1 | Marks the last header byte when a header CRC is requested |
| crc_dat_ins | output | 1 | Marks the last data byte when a data CRC is requested |
| tx_irq | output | NCH | Per-channel completion interrupt pulse |

## Verification
A wrong slot pointer or table base shows up at the next write-back, whose address no longer matches the slot that was expected to retire. That is within one packet. A corrupted byte pointer or remaining count shows up on the first wrong byte or on a misplaced marker in the FIFO stream, and the bench compares that stream entry by entry on every clock. Wrong arbitration state changes which channel's bytes come next, so the first packet served out of order fails. A tx_en flag that stays stuck high keeps the engine reading and never lets the run settle, and the idle wait catches it.

// File: rtl/spw_txd_pkg.sv
package spw_txd_pkg;

    localparam int WORD_W        = 32;
    localparam int DESC_BYTES    = 16;
    localparam int TABLE_BYTES   = 1024;
    localparam int SLOT_W        = $clog2(TABLE_BYTES / DESC_BYTES);
    localparam int SLOT_OFS_W    = $clog2(DESC_BYTES);
    localparam int TABLE_ALIGN_W = SLOT_W + SLOT_OFS_W;
    localparam int SLOT_LAST     = (TABLE_BYTES / DESC_BYTES) - 1;
    localparam int HLEN_W        = 8;
    localparam int DLEN_W        = 24;

    // control word bit positions
    localparam int B_EN   = 12;
    localparam int B_WRAP = 13;
    localparam int B_IE   = 14;
    localparam int B_HC   = 16;
    localparam int B_DC   = 17;

    typedef struct packed {
        logic              en;
        logic              wrap;
        logic              irq_en;
        logic              crc_hdr;
        logic              crc_dat;
        logic [HLEN_W-1:0] hlen;
    } ctl_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTL,
        S_HPTR,
        S_DLEN,
        S_DPTR,
        S_FETCH,
        S_PUSH,
        S_EOP,
        S_WBACK
    } state_t;

    typedef enum logic {
        P_HDR,
        P_DAT
    } part_t;

    function automatic ctl_t unpack_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.en      = w[B_EN];
        c.wrap    = w[B_WRAP];
        c.irq_en  = w[B_IE];
        c.crc_hdr = w[B_HC];
        c.crc_dat = w[B_DC];
        c.hlen    = w[HLEN_W-1:0];
        return c;
    endfunction

    // big-endian lane select: lane 0 is the most significant byte
    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                             input logic [1:0]        lane);
        return w[(3 - int'(lane)) * 8 +: 8];
    endfunction

    function automatic logic [WORD_W-1:0] retire_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r       = w;
        r[B_EN] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txd_chan_state.sv
module txd_chan_state
    import spw_txd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       base_we,
    input  logic [AW-TABLE_ALIGN_W-1:0] base_hi_din,
    input  logic                       en_set,
    input  logic                       en_clr,
    input  logic                       adv,
    input  logic                       adv_wrap,
    output logic                       en,
    output logic [AW-1:0]              slot_addr
);
    localparam int HI_W = AW - TABLE_ALIGN_W;

    logic [HI_W-1:0]   base_hi;
    logic [SLOT_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            slot    <= '0;
            en      <= 1'b0;
        end else begin
            if (base_we) begin
                base_hi <= base_hi_din;
                slot    <= '0;
            end else if (adv) begin
                if (adv_wrap || slot == SLOT_W'(SLOT_LAST))
                    slot <= '0;
                else
                    slot <= slot + 1'b1;
            end
            if (en_set)
                en <= 1'b1;
            else if (en_clr)
                en <= 1'b0;
        end
    end

    assign slot_addr = {base_hi, slot, {SLOT_OFS_W{1'b0}}};

    a_r9_base_resets_slot: assert property (@(posedge clk) disable iff (rst)
        base_we |=> slot_addr[TABLE_ALIGN_W-1:0] == '0);

    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        en_set |=> en);

endmodule

// File: rtl/txd_rr_arb.sv
module txd_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] gnt
);
    int idx;

    // scan from farthest to nearest so the nearest requester wins
    always_comb begin
        any = 1'b0;
        gnt = last;
        idx = 0;
        for (int k = N; k >= 1; k--) begin
            idx = (int'(last) + k) % N;
            if (req[idx]) begin
                any = 1'b1;
                gnt = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/spw_txdesc_engine.sv
module spw_txdesc_engine
    import spw_txd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int HI_W = AW - TABLE_ALIGN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    tbl_base_we,
    input  logic [HI_W-1:0]   tbl_base,
    input  logic [NCH-1:0]    tx_en_set,
    output logic [NCH-1:0]    tx_en,
    output logic              mem_rd_req,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [8:0]        fifo_data,
    output logic              crc_hdr_ins,
    output logic              crc_dat_ins,
    output logic [NCH-1:0]    tx_irq
);

    state_t              st;
    part_t               part;
    logic [CW-1:0]       cur;
    logic [CW-1:0]       last;
    ctl_t                ctl;
    logic [WORD_W-1:0]   w0;
    logic [AW-1:0]       hptr;
    logic [AW-1:0]       dptr;
    logic [AW-1:0]       bptr;
    logic [DLEN_W-1:0]   dlen;
    logic [DLEN_W-1:0]   left;
    logic [WORD_W-1:0]   word;

    logic [NCH-1:0]      en_clr;
    logic [NCH-1:0]      adv;
    logic [AW-1:0]       slot_addr [NCH];
    logic [AW-1:0]       cur_addr;
    logic                arb_any;
    logic [CW-1:0]       arb_gnt;
    logic                rd_ack;
    logic                wr_done;
    logic                push_ok;
    logic                last_byte;
    logic [NCH-1:0]      cur_hot;

    // per-channel base, slot pointer and enable flag
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        txd_chan_state #(.AW(AW)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .base_we    (tbl_base_we[g]),
            .base_hi_din(tbl_base),
            .en_set     (tx_en_set[g]),
            .en_clr     (en_clr[g]),
            .adv        (adv[g]),
            .adv_wrap   (ctl.wrap),
            .en         (tx_en[g]),
            .slot_addr  (slot_addr[g])
        );
    end

    txd_rr_arb #(.N(NCH), .IW(CW)) u_arb (
        .req (tx_en),
        .last(last),
        .any (arb_any),
        .gnt (arb_gnt)
    );

    assign cur_addr  = slot_addr[cur];
    assign cur_hot   = NCH'(1) << cur;
    assign rd_ack    = mem_rd_req && mem_rd_ack;
    assign wr_done   = mem_wr_req && mem_wr_ack;
    assign push_ok   = !fifo_full;
    assign last_byte = (left == DLEN_W'(1));

    // memory port
    always_comb begin
        mem_rd_req  = 1'b0;
        mem_rd_addr = cur_addr;
        unique case (st)
            S_CTL:   begin mem_rd_req = 1'b1; mem_rd_addr = cur_addr; end
            S_HPTR:  begin mem_rd_req = 1'b1; mem_rd_addr = cur_addr | AW'(4); end
            S_DLEN:  begin mem_rd_req = 1'b1; mem_rd_addr = cur_addr | AW'(8); end
            S_DPTR:  begin mem_rd_req = 1'b1; mem_rd_addr = cur_addr | AW'(12); end
            S_FETCH: begin mem_rd_req = 1'b1; mem_rd_addr = {bptr[AW-1:2], 2'b00}; end
            default: ;
        endcase
    end

    assign mem_wr_req  = (st == S_WBACK);
    assign mem_wr_addr = cur_addr;
    assign mem_wr_data = retire_word(w0);

    // FIFO side
    assign fifo_push   = ((st == S_PUSH) || (st == S_EOP)) && push_ok;
    assign fifo_data   = (st == S_EOP) ? 9'h100 : {1'b0, pick_byte(word, bptr[1:0])};
    assign crc_hdr_ins = (st == S_PUSH) && push_ok && (part == P_HDR) && last_byte && ctl.crc_hdr;
    assign crc_dat_ins = (st == S_PUSH) && push_ok && (part == P_DAT) && last_byte && ctl.crc_dat;

    // channel side effects
    assign en_clr = (st == S_CTL && rd_ack && !mem_rd_data[B_EN]) ? cur_hot : '0;
    assign adv    = wr_done ? cur_hot : '0;
    assign tx_irq = (wr_done && ctl.irq_en) ? cur_hot : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            part <= P_HDR;
            cur  <= '0;
            last <= CW'(NCH - 1);
            ctl  <= '0;
            w0   <= '0;
            hptr <= '0;
            dptr <= '0;
            bptr <= '0;
            dlen <= '0;
            left <= '0;
            word <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (arb_any) begin
                        cur <= arb_gnt;
                        st  <= S_CTL;
                    end
                end
                S_CTL: begin
                    if (rd_ack) begin
                        w0  <= mem_rd_data;
                        ctl <= unpack_ctl(mem_rd_data);
                        if (!mem_rd_data[B_EN]) begin
                            last <= cur;
                            st   <= S_IDLE;
                        end else begin
                            st <= S_HPTR;
                        end
                    end
                end
                S_HPTR: begin
                    if (rd_ack) begin
                        hptr <= AW'(mem_rd_data);
                        st   <= S_DLEN;
                    end
                end
                S_DLEN: begin
                    if (rd_ack) begin
                        dlen <= mem_rd_data[DLEN_W-1:0];
                        st   <= S_DPTR;
                    end
                end
                S_DPTR: begin
                    if (rd_ack) begin
                        dptr <= AW'(mem_rd_data);
                        if (ctl.hlen != '0) begin
                            part <= P_HDR;
                            bptr <= hptr;
                            left <= DLEN_W'(ctl.hlen);
                            st   <= S_FETCH;
                        end else if (dlen != '0) begin
                            part <= P_DAT;
                            bptr <= AW'(mem_rd_data);
                            left <= dlen;
                            st   <= S_FETCH;
                        end else begin
                            st <= S_WBACK;
                        end
                    end
                end
                S_FETCH: begin
                    if (rd_ack) begin
                        word <= mem_rd_data;
                        st   <= S_PUSH;
                    end
                end
                S_PUSH: begin
                    if (push_ok) begin
                        bptr <= bptr + 1'b1;
                        left <= left - 1'b1;
                        if (last_byte) begin
                            if (part == P_HDR && dlen != '0) begin
                                part <= P_DAT;
                                bptr <= dptr;
                                left <= dlen;
                                st   <= S_FETCH;
                            end else begin
                                st <= S_EOP;
                            end
                        end else if (bptr[1:0] == 2'b11) begin
                            st <= S_FETCH;
                        end
                    end
                end
                S_EOP: begin
                    if (push_ok) st <= S_WBACK;
                end
                S_WBACK: begin
                    if (wr_done) begin
                        last <= cur;
                        st   <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !fifo_full);

    a_r6_hdr_crc_on_byte: assert property (@(posedge clk) disable iff (rst)
        crc_hdr_ins |-> fifo_push && !fifo_data[8]);

    a_r6_dat_crc_on_byte: assert property (@(posedge clk) disable iff (rst)
        crc_dat_ins |-> fifo_push && !fifo_data[8]);

    a_r6_one_crc_strobe: assert property (@(posedge clk) disable iff (rst)
        !(crc_hdr_ins && crc_dat_ins));

    a_r13_read_held: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

    a_r13_single_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_req && mem_wr_req));

    a_r7_wb_on_slot: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> mem_wr_addr[SLOT_OFS_W-1:0] == '0 && !mem_wr_data[B_EN]);

    a_r2_marker_then_wb: assert property (@(posedge clk) disable iff (rst)
        fifo_push && fifo_data[8] |=> mem_wr_req);

    a_r8_irq_with_wb: assert property (@(posedge clk) disable iff (rst)
        (tx_irq != '0) |-> wr_done && $onehot0(tx_irq));

    a_r11_grant_requested: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && arb_any) |-> tx_en[arb_gnt]);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> !mem_rd_req && !mem_wr_req);

endmodule

// File: tb/spw_txdesc_engine_tb.sv
module spw_txdesc_engine_tb;
    import spw_txd_pkg::*;

    localparam int NCH  = 4;
    localparam int AW   = 32;
    localparam int HI_W = AW - TABLE_ALIGN_W;
    localparam int MEMW = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NCH-1:0]  tbl_base_we = '0;
    logic [HI_W-1:0] tbl_base    = '0;
    logic [NCH-1:0]  tx_en_set   = '0;
    logic [NCH-1:0]  tx_en;
    logic            mem_rd_req;
    logic [AW-1:0]   mem_rd_addr;
    logic            mem_rd_ack  = 1'b0;
    logic [31:0]     mem_rd_data = '0;
    logic            mem_wr_req;
    logic [AW-1:0]   mem_wr_addr;
    logic [31:0]     mem_wr_data;
    logic            mem_wr_ack  = 1'b0;
    logic            fifo_full   = 1'b0;
    logic            fifo_push;
    logic [8:0]      fifo_data;
    logic            crc_hdr_ins;
    logic            crc_dat_ins;
    logic [NCH-1:0]  tx_irq;

    spw_txdesc_engine #(.NCH(NCH), .AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .tbl_base_we(tbl_base_we), .tbl_base(tbl_base),
        .tx_en_set(tx_en_set), .tx_en(tx_en),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_data(fifo_data),
        .crc_hdr_ins(crc_hdr_ins), .crc_dat_ins(crc_dat_ins), .tx_irq(tx_irq)
    );

    logic [31:0] mem [MEMW];

    typedef struct {
        logic [8:0] d;
        bit         ch;
        bit         cd;
    } push_t;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        int          ch;
        bit          irq;
    } wb_t;

    push_t pq[$];
    wb_t   wq[$];
    push_t pe;
    wb_t   we;

    int          n_run  = 0;
    int          n_fail = 0;
    int          cyc    = 0;
    int          mptr [NCH];
    int          mlast;
    int          mbase [NCH];
    bit          active = 1'b0;
    logic        prev_req  = 1'b0;
    logic        prev_ack  = 1'b0;
    logic [31:0] prev_addr = '0;

    function automatic logic [7:0] mbyte(input int a);
        logic [31:0] w;
        w = mem[(a >> 2) % MEMW];
        return w[(3 - (a & 3)) * 8 +: 8];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl_word(input bit en, input bit wrap, input bit ie,
                                             input bit hc, input bit dc, input int hl);
        logic [31:0] w;
        w         = '0;
        w[7:0]    = hl[7:0];
        w[B_EN]   = en;
        w[B_WRAP] = wrap;
        w[B_IE]   = ie;
        w[B_HC]   = hc;
        w[B_DC]   = dc;
        return w;
    endfunction

    task automatic put_desc(input int ch, input int idx, input logic [31:0] w0,
                            input int ha, input int dl, input int da);
        int a;
        a = (mbase[ch] + idx * DESC_BYTES) >> 2;
        mem[a]     = w0;
        mem[a + 1] = ha;
        mem[a + 2] = dl;
        mem[a + 3] = da;
    endtask

    // behavioural model: run the arbitration and produce the expected streams
    task automatic model_run(input logic [NCH-1:0] mask);
        bit          seen [int];
        logic [NCH-1:0] men;
        int          ch, c, a, hl, dl, ha, da;
        logic [31:0] w0;
        men = mask;
        while (men != '0) begin
            ch = 0;
            for (int k = 1; k <= NCH; k++) begin
                c = (mlast + k) % NCH;
                if (men[c]) begin
                    ch = c;
                    break;
                end
            end
            a  = mbase[ch] + mptr[ch] * DESC_BYTES;
            w0 = mem[a >> 2];
            if (!w0[B_EN] || seen.exists(a)) begin
                men[ch] = 1'b0;
                mlast   = ch;
                continue;
            end
            hl = int'(w0[7:0]);
            ha = int'(mem[(a >> 2) + 1]);
            dl = int'(mem[(a >> 2) + 2] & 32'h00FF_FFFF);
            da = int'(mem[(a >> 2) + 3]);
            for (int i = 0; i < hl; i++)
                pq.push_back('{{1'b0, mbyte(ha + i)}, (i == hl - 1) && w0[B_HC], 1'b0});
            for (int i = 0; i < dl; i++)
                pq.push_back('{{1'b0, mbyte(da + i)}, 1'b0, (i == dl - 1) && w0[B_DC]});
            if (hl != 0 || dl != 0)
                pq.push_back('{9'h100, 1'b0, 1'b0});
            wq.push_back('{a, w0 & ~(32'd1 << B_EN), ch, w0[B_IE]});
            seen[a]  = 1'b1;
            mptr[ch] = (w0[B_WRAP] || mptr[ch] == SLOT_LAST) ? 0 : mptr[ch] + 1;
            mlast    = ch;
        end
    endtask

    task automatic set_base(input int ch, input int addr);
        @(negedge clk);
        tbl_base_we     = NCH'(1) << ch;
        tbl_base        = HI_W'(addr >> TABLE_ALIGN_W);
        @(negedge clk);
        tbl_base_we     = '0;
        mbase[ch]       = addr;
        mptr[ch]        = 0;
    endtask

    task automatic start(input logic [NCH-1:0] mask);
        model_run(mask);
        @(negedge clk);
        tx_en_set = mask;
        @(negedge clk);
        tx_en_set = '0;
        // R12: the strobe sets the flags, seen one cycle later
        check((tx_en & mask) == mask, "R12", "tx_en after set", 32'(tx_en), 32'(mask));
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        while ((pq.size() != 0 || wq.size() != 0 || tx_en != '0) && n < 40000) begin
            @(negedge clk);
            n++;
        end
        repeat (8) @(negedge clk);
        check(tx_en == '0, "R10", {req, " tx_en cleared at end"}, 32'(tx_en), 32'd0);
        check(pq.size() == 0, req, "pending pushes", 32'(pq.size()), 32'd0);
        check(wq.size() == 0, req, "pending write-backs", 32'(wq.size()), 32'd0);
    endtask

    // memory and FIFO responder, updated just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst || !active) begin
            mem_rd_ack = 1'b0;
            mem_wr_ack = 1'b0;
            fifo_full  = 1'b0;
        end else begin
            mem_rd_ack  = mem_rd_req && ($urandom % 3 != 0);
            mem_rd_data = mem[(mem_rd_addr >> 2) % MEMW];
            mem_wr_ack  = mem_wr_req && ($urandom % 2 == 0);
            fifo_full   = ($urandom % 4 == 0);
        end
    end

    // comparison against the model on every clock
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
            if (prev_req && !prev_ack)
                check(mem_rd_req && mem_rd_addr == prev_addr, "R13", "read held",
                      mem_rd_addr, prev_addr);
            check(!(mem_rd_req && mem_wr_req), "R13", "single access",
                  {mem_rd_req, mem_wr_req}, 32'd0);
            prev_req  = mem_rd_req;
            prev_ack  = mem_rd_ack;
            prev_addr = mem_rd_addr;
            if (fifo_push) begin
                check(!fifo_full, "R5", "push while full", 32'(fifo_full), 32'd0);
                if (pq.size() == 0) begin
                    check(1'b0, "R2", "unexpected push", 32'(fifo_data), 32'hFFFF);
                end else begin
                    pe = pq.pop_front();
                    check(fifo_data == pe.d, "R2", "fifo entry", 32'(fifo_data), 32'(pe.d));
                    check(crc_hdr_ins == pe.ch, "R6", "header crc strobe",
                          32'(crc_hdr_ins), 32'(pe.ch));
                    check(crc_dat_ins == pe.cd, "R6", "data crc strobe",
                          32'(crc_dat_ins), 32'(pe.cd));
                end
            end else if (crc_hdr_ins || crc_dat_ins) begin
                check(1'b0, "R6", "crc strobe without push",
                      {crc_hdr_ins, crc_dat_ins}, 32'd0);
            end
            if (mem_wr_req && mem_wr_ack) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R10", "unexpected write-back", mem_wr_addr, 32'hFFFF_FFFF);
                end else begin
                    we = wq.pop_front();
                    check(mem_wr_addr == we.a, "R9", "write-back slot (R1)", mem_wr_addr, we.a);
                    check(mem_wr_data == we.d, "R7", "write-back word", mem_wr_data, we.d);
                    check(tx_irq == (we.irq ? NCH'(1) << we.ch : NCH'(0)), "R8", "irq",
                          32'(tx_irq), we.irq ? 32'(1) << we.ch : 32'd0);
                end
                mem[(mem_wr_addr >> 2) % MEMW] = mem_wr_data;
            end else if (tx_irq != '0) begin
                check(1'b0, "R8", "irq outside write-back", 32'(tx_irq), 32'd0);
            end
        end
    end

    initial begin
        for (int i = 0; i < MEMW; i++)
            mem[i] = (i < 1024) ? 32'd0 : (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
        for (int c = 0; c < NCH; c++) begin
            mbase[c] = c * TABLE_BYTES;
            mptr[c]  = 0;
        end
        mlast = NCH - 1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_en == '0, "R12", "reset tx_en", 32'(tx_en), 32'd0);
        check(!fifo_push && !mem_wr_req, "R5", "reset outputs quiet",
              {fifo_push, mem_wr_req}, 32'd0);
        repeat (10) @(negedge clk);
        check(!mem_rd_req, "R12", "no access without enable", 32'(mem_rd_req), 32'd0);
        active = 1'b1;
        for (int c = 0; c < NCH; c++) set_base(c, c * TABLE_BYTES);

        // R1 R2 R6 R8: unaligned header and data, both CRC flags, interrupt
        put_desc(0, 0, ctl_word(1, 0, 1, 1, 1, 3), 32'h2001, 5, 32'h2102);
        start(4'b0001);
        wait_idle("R2");

        // R3: header-only and data-only packets, CRC flags on the skipped parts
        put_desc(0, 1, ctl_word(1, 0, 0, 1, 0, 0), 32'h2500, 6, 32'h2203);
        put_desc(0, 2, ctl_word(1, 0, 1, 0, 1, 4), 32'h2300, 0, 32'h2600);
        start(4'b0001);
        wait_idle("R3");

        // R4: empty descriptor retires without traffic
        put_desc(0, 3, ctl_word(1, 0, 1, 1, 1, 0), 32'h2000, 0, 32'h2000);
        start(4'b0001);
        wait_idle("R4");

        // R9: wrap bit returns to slot 0; slot 1 is never reached
        put_desc(1, 0, ctl_word(1, 1, 0, 0, 0, 0), 0, 2, 32'h2700);
        put_desc(1, 1, ctl_word(1, 0, 0, 0, 0, 1), 32'h2800, 1, 32'h2800);
        start(4'b0010);
        wait_idle("R9");
        put_desc(1, 0, ctl_word(1, 1, 1, 0, 1, 2), 32'h2710, 3, 32'h2721);
        start(4'b0010);
        wait_idle("R9");

        // R11: round-robin over three channels with different queue depths
        set_base(0, 0);
        set_base(2, 2 * TABLE_BYTES);
        put_desc(0, 0, ctl_word(1, 0, 0, 0, 0, 2), 32'h2900, 3, 32'h2910);
        put_desc(0, 1, ctl_word(1, 0, 1, 0, 0, 0), 0, 4, 32'h2921);
        put_desc(0, 2, ctl_word(0, 0, 0, 0, 0, 0), 0, 0, 0);
        put_desc(2, 0, ctl_word(1, 0, 0, 1, 0, 1), 32'h2A00, 2, 32'h2A13);
        put_desc(2, 1, ctl_word(1, 0, 1, 0, 0, 5), 32'h2A22, 0, 0);
        put_desc(2, 2, ctl_word(1, 0, 0, 0, 1, 0), 0, 7, 32'h2A31);
        put_desc(2, 3, ctl_word(0, 0, 0, 0, 0, 0), 0, 0, 0);
        set_base(1, TABLE_BYTES);
        put_desc(1, 0, ctl_word(1, 0, 1, 0, 0, 1), 32'h2B00, 1, 32'h2B05);
        start(4'b0111);
        wait_idle("R11");

        // R9: sixty-four slots, then the pointer is back at slot 0
        for (int i = 0; i < 64; i++)
            put_desc(3, i, ctl_word(1, 0, 0, 0, 0, 0), 0, 1, 32'h2C00 + i);
        start(4'b1000);
        wait_idle("R9");
        put_desc(3, 0, ctl_word(1, 0, 1, 0, 0, 0), 0, 2, 32'h2D02);
        start(4'b1000);
        wait_idle("R9");

        // R2: longest header, odd alignment, longer data
        set_base(2, 2 * TABLE_BYTES);
        put_desc(2, 0, ctl_word(1, 0, 0, 1, 1, 255), 32'h3003, 40, 32'h3201);
        put_desc(2, 1, ctl_word(0, 0, 0, 0, 0, 0), 0, 0, 0);
        start(4'b0100);
        wait_idle("R2");

        // R10: channels whose current slot is disabled only drop their flag
        set_base(1, TABLE_BYTES);
        put_desc(1, 0, ctl_word(0, 0, 1, 0, 0, 3), 32'h2000, 3, 32'h2000);
        set_base(3, 3 * TABLE_BYTES);
        put_desc(3, 0, ctl_word(0, 0, 1, 0, 0, 3), 32'h2000, 3, 32'h2000);
        start(4'b1010);
        wait_idle("R10");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule